// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings up to two SDRAM banks out of reset by writing a fixed series of command words to a command-mode register interface. After each command write it waits a programmed settling time, measured in whole microseconds from the system clock, and then waits for the busy input to fall before it moves on. When a bank has reached normal mode, the block writes the refresh-timer value for that bank and then starts the next enabled bank.

A single start pulse captures the bank enable mask, the CAS latency and the refresh count. It also captures the option to hold the memory controller disabled while the sequence runs. Completion shows as a done level. If the busy input stays high past a programmable number of cycles, the sequence stops and a sticky error flag is raised. The settling delays are parameters, so the waits come to an exact number of cycles.

Top module: `sdram_init_seq`

## Requirements
- R1: For each enabled bank, the command mode codes in bits 2:0 are issued in this order: 1 (clock start), 2 (precharge all), 3 (auto-refresh), 4 (load mode register), 0 (normal). Each command is one single-cycle pulse of `cmd_we_o`.
- R2: Bit 4 of the command word selects bank 1 (`bank_en_i[0]`) and bit 3 selects bank 2 (`bank_en_i[1]`). Exactly one of the two bits is set. Bank 1 is served before bank 2, and a disabled bank issues no commands.
- R3: Bits 8:5 of the command word hold 7 (eight refresh cycles) on the auto-refresh command and 0 on every other command.
- R4: On the load-mode command, the mode payload starting at bit 9 has burst length 0 in its bits 2:0 and the CAS latency in its bits 6:4, which are command bits 15:13. On every other command the payload is zero.
- R5: After the clock-start command, the next command follows no sooner than PWRUP_US*CLK_MHZ+3 cycles. After precharge, auto-refresh and load-mode, the next command or the refresh write follows no sooner than STEP_US*CLK_MHZ+3 cycles. When busy is already low, these gaps are exact.
- R6: While `busy_i` is high in the polling phase, no further command or refresh write is issued. If busy is last seen high B cycles after a strobe, the next strobe comes B+2 cycles after that strobe at the earliest.
- R7: After a bank's normal-mode command has completed, `rtr_we_o` pulses once and `rtr_o` carries the refresh count shifted left by one. A refresh count of 0 selects the default of 8196.
- R8: With the gate option set, `ctrl_en_o` goes low when the sequence starts and stays low during every command. It returns high when the last bank finishes. With the option clear, `ctrl_en_o` stays high.
- R9: If busy stays high for `busy_tmo_i` polling cycles, the sequence aborts, `err_o` goes high and stays high, `done_o` stays low, and no further command is issued until the next start, which clears `err_o`.
- R10: A start pulse during a running sequence is ignored. `done_o` is a level that the next accepted start clears in the following cycle. An empty enable mask completes without issuing any command.
- R11: After reset, `cmd_we_o`, `rtr_we_o`, `done_o` and `err_o` are low and `ctrl_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the configuration inputs |
| bank_en_i | input | 2 | Enable mask; bit 0 is bank 1, bit 1 is bank 2 |
| cas_lat_i | input | CAS_W | CAS latency placed in the mode payload |
| ref_count_i | input | REF_W | Refresh count; 0 selects the default |
| ctrl_gate_i | input | 1 | Hold the controller disabled during the sequence |
| busy_i | input | 1 | Busy status from the command interface |
| busy_tmo_i | input | TMO_W | Maximum number of busy polling cycles |
| cmd_o | output | CMD_W | Command word: mode, bank, refresh count, mode payload |
| cmd_we_o | output | 1 | Command write strobe |
| rtr_o | output | REF_W+1 | Refresh-timer value |
| rtr_we_o | output | 1 | Refresh-timer load strobe |
| ctrl_en_o | output | 1 | Controller enable |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Sequence aborted on busy timeout |

## Verification
Every strobe is registered, so a command appears the cycle after the state machine's issue step. The bench tags each strobe with a cycle stamp taken at the falling edge. Its model drives busy high starting the falling edge after a strobe, for a set number of cycles. Each gap between strobes is therefore known exactly: the larger of the delay in cycles plus 3 and the busy length plus 2. The bench compares the exact gap, not a lower bound. The done and error levels are sampled at the falling edge that follows the accepting clock edge, and the timeout test waits a margin beyond the programmed limit before it reads the sticky flag.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int N_BANKS = 2;
  localparam int N_STEPS = 5;
  localparam int BANK_TOP_BIT = 4;
  localparam int AR_LSB = 5;
  localparam int AR_W = 4;
  localparam int MR_LSB = 9;
  localparam int MR_CAS_LSB = 4;
  localparam logic [AR_W-1:0] AR_EIGHT = 4'd7;

  typedef enum logic [2:0] {
    MODE_NORMAL     = 3'd0,
    MODE_CLK_START  = 3'd1,
    MODE_PRECHARGE  = 3'd2,
    MODE_AUTO_REF   = 3'd3,
    MODE_LOAD_MR    = 3'd4,
    MODE_SELF_REF   = 3'd5,
    MODE_POWER_DOWN = 3'd6
  } sdram_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_ISSUE,
    ST_DELAY,
    ST_POLL,
    ST_RTR
  } seq_state_e;

  function automatic sdram_mode_e step_mode(input logic [2:0] step);
    case (step)
      3'd0:    return MODE_CLK_START;
      3'd1:    return MODE_PRECHARGE;
      3'd2:    return MODE_AUTO_REF;
      3'd3:    return MODE_LOAD_MR;
      default: return MODE_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/sdram_us_timer.sv
module sdram_us_timer #(
  parameter int CLK_MHZ = 100,
  parameter int US_W    = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [US_W-1:0] us_i,
  output logic            done_o
);
  localparam int PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_MHZ - 1);

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (load_i) begin
      pre_q <= PRE_MAX;
      us_q  <= us_i;
    end else if (us_q != '0) begin
      if (pre_q == '0) begin
        pre_q <= PRE_MAX;
        us_q  <= us_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  assign done_o = (us_q == '0);
endmodule

// File: rtl/sdram_busy_watch.sv
module sdram_busy_watch #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             poll_i,
  input  logic             busy_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!poll_i)                     cnt_q <= '0;
    else if (busy_i && (cnt_q != '1))     cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = poll_i && busy_i && (cnt_q >= tmo_i);
endmodule

// File: rtl/sdram_cmd_pack.sv
module sdram_cmd_pack
  import sdram_init_pkg::*;
#(
  parameter int CAS_W = 3,
  parameter int MR_W  = 13,
  parameter int BI_W  = 2,
  localparam int CMD_W = MR_LSB + MR_W
) (
  input  logic [BI_W-1:0]  bank_i,
  input  logic [2:0]       step_i,
  input  logic [CAS_W-1:0] cas_i,
  output logic [CMD_W-1:0] cmd_o
);
  sdram_mode_e          mode;
  logic [N_BANKS-1:0]   bank_sel;
  logic [AR_W-1:0]      ar_cnt;
  logic [MR_W-1:0]      mr_val;

  // bank 1 sits at the top bit of the field, bank 2 just below it
  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    assign bank_sel[N_BANKS-1-g] = (bank_i == BI_W'(g));
  end

  always_comb begin
    mode   = step_mode(step_i);
    ar_cnt = (mode == MODE_AUTO_REF) ? AR_EIGHT : '0;
    mr_val = '0;
    if (mode == MODE_LOAD_MR) mr_val[MR_CAS_LSB +: CAS_W] = cas_i;
    cmd_o = {mr_val, ar_cnt, bank_sel, mode};
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int PWRUP_US = 200,
  parameter int STEP_US  = 100,
  parameter int CAS_W    = 3,
  parameter int REF_W    = 14,
  parameter int DEF_REF  = 8196,
  parameter int TMO_W    = 16,
  parameter int MR_W     = 13,
  localparam int CMD_W   = MR_LSB + MR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_BANKS-1:0] bank_en_i,
  input  logic [CAS_W-1:0]   cas_lat_i,
  input  logic [REF_W-1:0]   ref_count_i,
  input  logic               ctrl_gate_i,
  input  logic               busy_i,
  input  logic [TMO_W-1:0]   busy_tmo_i,
  output logic [CMD_W-1:0]   cmd_o,
  output logic               cmd_we_o,
  output logic [REF_W:0]     rtr_o,
  output logic               rtr_we_o,
  output logic               ctrl_en_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int BI_W   = $clog2(N_BANKS + 1);
  localparam int MAX_US = (PWRUP_US > STEP_US) ? PWRUP_US : STEP_US;
  localparam int US_W   = $clog2(MAX_US + 1);
  localparam logic [REF_W-1:0] REF_DFLT = REF_W'(DEF_REF);

  seq_state_e         state_q;
  logic [N_BANKS-1:0] en_q;
  logic [BI_W-1:0]    bank_q;
  logic [2:0]         step_q;
  logic [CAS_W-1:0]   cas_q;
  logic [REF_W-1:0]   ref_q;
  logic [CMD_W-1:0]   cmd_q;
  logic               cmd_we_q, rtr_we_q, ctrl_en_q, done_q, err_q;
  logic [REF_W:0]     rtr_q;

  logic [CMD_W-1:0]   cmd_next;
  logic [US_W-1:0]    delay_us;
  logic               tmr_load, tmr_done, expired;

  always_comb begin
    case (step_q)
      3'd0:    delay_us = US_W'(PWRUP_US);
      3'd1,
      3'd2,
      3'd3:    delay_us = US_W'(STEP_US);
      default: delay_us = '0;
    endcase
  end

  assign tmr_load = (state_q == ST_ISSUE);

  sdram_cmd_pack #(.CAS_W(CAS_W), .MR_W(MR_W), .BI_W(BI_W)) u_pack (
    .bank_i (bank_q),
    .step_i (step_q),
    .cas_i  (cas_q),
    .cmd_o  (cmd_next)
  );

  sdram_us_timer #(.CLK_MHZ(CLK_MHZ), .US_W(US_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .us_i   (delay_us),
    .done_o (tmr_done)
  );

  sdram_busy_watch #(.TMO_W(TMO_W)) u_watch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .poll_i    (state_q == ST_POLL),
    .busy_i    (busy_i),
    .tmo_i     (busy_tmo_i),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      en_q      <= '0;
      bank_q    <= '0;
      step_q    <= '0;
      cas_q     <= '0;
      ref_q     <= '0;
      cmd_q     <= '0;
      cmd_we_q  <= 1'b0;
      rtr_q     <= '0;
      rtr_we_q  <= 1'b0;
      ctrl_en_q <= 1'b1;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      cmd_we_q <= 1'b0;
      rtr_we_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          en_q    <= bank_en_i;
          cas_q   <= cas_lat_i;
          ref_q   <= (ref_count_i == '0) ? REF_DFLT : ref_count_i;
          bank_q  <= '0;
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          if (ctrl_gate_i) ctrl_en_q <= 1'b0;
          state_q <= ST_SELECT;
        end
        ST_SELECT: begin
          if (bank_q == BI_W'(N_BANKS)) begin
            done_q    <= 1'b1;
            ctrl_en_q <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (en_q[0]) begin
            step_q  <= '0;
            state_q <= ST_ISSUE;
          end else begin
            en_q   <= en_q >> 1;
            bank_q <= bank_q + 1'b1;
          end
        end
        ST_ISSUE: begin
          cmd_q    <= cmd_next;
          cmd_we_q <= 1'b1;
          state_q  <= ST_DELAY;
        end
        ST_DELAY: if (tmr_done) state_q <= ST_POLL;
        ST_POLL: begin
          if (expired) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (!busy_i) begin
            if (step_q == 3'(N_STEPS - 1)) begin
              state_q <= ST_RTR;
            end else begin
              step_q  <= step_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_RTR: begin
          rtr_q    <= {ref_q, 1'b0};
          rtr_we_q <= 1'b1;
          en_q     <= en_q >> 1;
          bank_q   <= bank_q + 1'b1;
          state_q  <= ST_SELECT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o     = cmd_q;
  assign cmd_we_o  = cmd_we_q;
  assign rtr_o     = rtr_q;
  assign rtr_we_o  = rtr_we_q;
  assign ctrl_en_o = ctrl_en_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int CMD_W = 22
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             ctrl_gate_i,
  input logic [CMD_W-1:0] cmd_o,
  input logic             cmd_we_o,
  input logic             rtr_we_o,
  input logic             ctrl_en_o,
  input logic             done_o,
  input logic             err_o
);
  logic last_normal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_normal_q <= 1'b0;
    else if (cmd_we_o) last_normal_q <= (cmd_o[2:0] == 3'd0);
  end

  p_mode_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_o |-> (cmd_o[2:0] <= 3'd4));

  p_strobe_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_o |=> !cmd_we_o);

  p_bank_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_o |-> ($countones(cmd_o[4:3]) == 1));

  p_ar_field_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_o |-> ((cmd_o[2:0] == 3'd3) ? (cmd_o[8:5] == 4'd7) : (cmd_o[8:5] == 4'd0)));

  p_payload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_o && (cmd_o[2:0] != 3'd4)) |-> (cmd_o[CMD_W-1:9] == '0));

  p_rtr_after_normal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtr_we_o |-> last_normal_q);

  p_ctrl_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_o && ctrl_gate_i) |-> !ctrl_en_o);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);

  p_done_err_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.CMD_W(CMD_W)) u_chk (.*);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb_top;
  localparam int CLK_T    = 10;
  localparam int MHZ      = 2;
  localparam int PWR      = 10;
  localparam int STP      = 5;
  localparam int CMD_W    = 22;
  localparam int REF_W    = 14;

  typedef struct packed {
    logic [1:0]  en;
    logic [2:0]  cas;
    logic [13:0] refc;
    logic        gate;
    logic [5:0]  blen;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{en: 2'b01, cas: 3'd2, refc: 14'd100,   gate: 1'b1, blen: 6'd3},
    '{en: 2'b10, cas: 3'd3, refc: 14'd1000,  gate: 1'b0, blen: 6'd3},
    '{en: 2'b11, cas: 3'd1, refc: 14'd0,     gate: 1'b1, blen: 6'd3},
    '{en: 2'b11, cas: 3'd7, refc: 14'd16383, gate: 1'b1, blen: 6'd25},
    '{en: 2'b00, cas: 3'd2, refc: 14'd5,     gate: 1'b1, blen: 6'd3},
    '{en: 2'b01, cas: 3'd0, refc: 14'd1,     gate: 1'b0, blen: 6'd0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] bank_en_i = '0;
  logic [2:0] cas_lat_i = '0;
  logic [REF_W-1:0] ref_count_i = '0;
  logic ctrl_gate_i = 1'b0;
  logic busy_i;
  logic [15:0] busy_tmo_i = 16'd1000;
  logic [CMD_W-1:0] cmd_o;
  logic cmd_we_o, rtr_we_o, ctrl_en_o, done_o, err_o;
  logic [REF_W:0] rtr_o;

  sdram_init_seq #(.CLK_MHZ(MHZ), .PWRUP_US(PWR), .STEP_US(STP)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .bank_en_i(bank_en_i),
    .cas_lat_i(cas_lat_i), .ref_count_i(ref_count_i), .ctrl_gate_i(ctrl_gate_i),
    .busy_i(busy_i), .busy_tmo_i(busy_tmo_i), .cmd_o(cmd_o), .cmd_we_o(cmd_we_o),
    .rtr_o(rtr_o), .rtr_we_o(rtr_we_o), .ctrl_en_o(ctrl_en_o), .done_o(done_o),
    .err_o(err_o)
  );

  always #(CLK_T/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // busy model and strobe log
  int busy_len = 0;
  int busy_cnt = 0;
  logic busy_q = 1'b0;
  logic stuck = 1'b0;
  assign busy_i = busy_q | stuck;

  int n_cmd = 0, n_rtr = 0;
  logic [CMD_W-1:0] cmd_log [16];
  int               cmd_t   [16];
  logic             cmd_ce  [16];
  logic [REF_W:0]   rtr_log [4];
  int               rtr_t   [4];

  always @(negedge clk) begin
    if (cmd_we_o) begin
      if (n_cmd < 16) begin
        cmd_log[n_cmd] = cmd_o;
        cmd_t[n_cmd]   = cyc;
        cmd_ce[n_cmd]  = ctrl_en_o;
      end
      n_cmd = n_cmd + 1;
      busy_cnt = busy_len;
      busy_q = (busy_len > 0);
    end else if (busy_cnt > 0) begin
      busy_cnt = busy_cnt - 1;
      if (busy_cnt == 0) busy_q = 1'b0;
    end
    if (rtr_we_o) begin
      if (n_rtr < 4) begin
        rtr_log[n_rtr] = rtr_o;
        rtr_t[n_rtr]   = cyc;
      end
      n_rtr = n_rtr + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [CMD_W-1:0] exp_cmd(input int b, input int s, input logic [2:0] cas);
    logic [CMD_W-1:0] w;
    w = '0;
    case (s)
      0: w[2:0] = 3'd1;
      1: w[2:0] = 3'd2;
      2: w[2:0] = 3'd3;
      3: w[2:0] = 3'd4;
      default: w[2:0] = 3'd0;
    endcase
    if (b == 0) w[4] = 1'b1; else w[3] = 1'b1;
    if (s == 2) w[8:5] = 4'd7;
    if (s == 3) w[15:13] = cas;
    return w;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_end(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (done_o || err_o) return;
      @(negedge clk);
    end
    chk(1'b0, "R10", "sequence end not reached", 0, 1);
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    bank_en_i = v.en; cas_lat_i = v.cas; ref_count_i = v.refc;
    ctrl_gate_i = v.gate; busy_len = v.blen;
    n_cmd = 0; n_rtr = 0;
    pulse_start();
    chk(done_o == 1'b0, "R10", "done cleared after start", done_o, 0);
    wait_end(4000);
  endtask

  task automatic check_vec(input vec_t v);
    int k, nb, d, g;
    k = 0; nb = 0;
    for (int b = 0; b < 2; b++) begin
      if (v.en[b]) begin
        for (int s = 0; s < 5; s++) begin
          if (k < n_cmd && k < 16) begin
            chk(cmd_log[k] == exp_cmd(b, s, v.cas), "R1 R2 R3 R4", "command word",
                cmd_log[k], exp_cmd(b, s, v.cas));
            chk(cmd_ce[k] == !v.gate, "R8", "ctrl enable during command", cmd_ce[k], !v.gate);
            if (s < 4 && k + 1 < n_cmd) begin
              d = (s == 0) ? PWR * MHZ : STP * MHZ;
              g = imax(d + 3, int'(v.blen) + 2);
              chk(cmd_t[k+1] - cmd_t[k] == g, (v.blen > 10) ? "R6" : "R5", "command gap",
                  cmd_t[k+1] - cmd_t[k], g);
            end
            if (s == 4 && nb < n_rtr) begin
              g = imax(3, int'(v.blen) + 2);
              chk(rtr_t[nb] - cmd_t[k] == g, "R6", "normal to refresh write gap",
                  rtr_t[nb] - cmd_t[k], g);
            end
          end
          k++;
        end
        if (nb < n_rtr)
          chk(rtr_log[nb] == (((v.refc == 0) ? 15'd8196 : {1'b0, v.refc}) << 1), "R7",
              "refresh timer value", rtr_log[nb],
              ((v.refc == 0) ? 15'd8196 : {1'b0, v.refc}) << 1);
        nb++;
      end
    end
    chk(n_cmd == k, "R2", "command count", n_cmd, k);
    chk(n_rtr == nb, "R7", "refresh write count", n_rtr, nb);
    chk(done_o == 1'b1 && err_o == 1'b0, "R10", "done level at end", {done_o, err_o}, 2);
    chk(ctrl_en_o == 1'b1, "R8", "ctrl enable after finish", ctrl_en_o, 1);
  endtask

  initial begin
    #(CLK_T * 190000);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cmd_we_o == 0 && rtr_we_o == 0, "R11", "strobes in reset", {cmd_we_o, rtr_we_o}, 0);
    chk(done_o == 0 && err_o == 0, "R11", "flags in reset", {done_o, err_o}, 0);
    chk(ctrl_en_o == 1, "R11", "ctrl enable in reset", ctrl_en_o, 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(cmd_we_o == 0 && done_o == 0 && err_o == 0 && ctrl_en_o == 1, "R11",
        "state after reset release", {cmd_we_o, done_o, err_o, ctrl_en_o}, 1);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i]);
      repeat (40) @(negedge clk);
      check_vec(VECS[i]);
    end

    // R10: start during a run is ignored
    @(negedge clk);
    bank_en_i = 2'b01; cas_lat_i = 3'd5; ref_count_i = 14'd77; ctrl_gate_i = 1'b0;
    busy_len = 3; n_cmd = 0; n_rtr = 0;
    pulse_start();
    repeat (15) @(negedge clk);
    bank_en_i = 2'b11;
    pulse_start();
    wait_end(4000);
    repeat (40) @(negedge clk);
    chk(n_cmd == 5, "R10", "commands with ignored restart", n_cmd, 5);
    chk(n_rtr == 1, "R10", "refresh writes with ignored restart", n_rtr, 1);
    chk(cmd_log[0][4:3] == 2'b10 && cmd_log[4][4:3] == 2'b10, "R10", "bank kept",
        {cmd_log[0][4:3], cmd_log[4][4:3]}, 10);

    // R10: done is a level cleared by the next start
    chk(done_o == 1, "R10", "done held", done_o, 1);
    repeat (10) @(negedge clk);
    chk(done_o == 1, "R10", "done still held", done_o, 1);
    n_cmd = 0; n_rtr = 0;
    pulse_start();
    chk(done_o == 0, "R10", "done cleared by new start", done_o, 0);
    wait_end(4000);

    // R9: busy timeout
    repeat (40) @(negedge clk);
    ctrl_gate_i = 1'b1; busy_tmo_i = 16'd40; stuck = 1'b1;
    n_cmd = 0; n_rtr = 0;
    pulse_start();
    wait_end(4000);
    chk(err_o == 1 && done_o == 0, "R9", "error on timeout", {err_o, done_o}, 2);
    chk(ctrl_en_o == 0, "R9", "ctrl stays off after abort", ctrl_en_o, 0);
    repeat (60) @(negedge clk);
    chk(err_o == 1, "R9", "error sticky", err_o, 1);
    chk(n_cmd == 1 && n_rtr == 0, "R9", "no commands after abort", n_cmd, 1);
    stuck = 1'b0; busy_tmo_i = 16'd1000;
    pulse_start();
    chk(err_o == 0, "R9", "error cleared by start", err_o, 0);
    wait_end(4000);
    chk(done_o == 1 && ctrl_en_o == 1, "R8", "recovery run completes", {done_o, ctrl_en_o}, 3);

    report();
  end
endmodule